// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block is the register file that a host sees for one bus-master DMA channel. It holds three registers. A command byte carries a run bit and a transfer-direction bit. A status byte carries an active flag, an error flag and an interrupt flag. A descriptor-table base address is also held. Host writes arrive as 1-, 2- or 4-byte accesses at a byte offset inside an 8-byte window. Each access replaces only the byte lanes it covers.

The block turns changes of the run bit into control of a separate descriptor engine. When the run bit rises, the current descriptor pointer reloads from the base address and, if the channel is idle, a one-cycle start pulse goes out. When the run bit falls, the block waits for any transfer still in flight to finish before it clears the active flag. The engine reports completion, pending work, errors and pointer advances back through dedicated inputs. The device interrupt line passes straight through to the host, and each rising edge latches the interrupt flag.

Top module: `dmach_regfile`

## Requirements
- R1: Reset leaves the command byte, the status byte, the base address and the descriptor pointer at zero, and `eng_start` low.
- R2: A command write at offset 0 keeps only bit 0 (run) and bit 3 (direction) of its byte. It reads back with all other bits zero, and `eng_dir` shows bit 3.
- R3: A command write that raises the run bit reloads `desc_ptr` from the base address. If the active flag (status bit 0) was clear, the same write sets it and `eng_start` is high for exactly the one cycle that follows. If the active flag was already set, no pulse is produced.
- R4: A command write that leaves the run bit unchanged produces no start pulse, leaves `desc_ptr` alone and leaves the active flag alone.
- R5: A command write that drops the run bit clears the active flag at that clock edge when `eng_busy` is low. Otherwise the flag stays set until the first edge at which `eng_busy` is low. A later run-bit rise cancels the pending clear.
- R6: Base address writes replace only the addressed byte lanes of offsets 4 to 7, and bits 1:0 of the stored address always read as zero.
- R7: A read returns, right-justified and zero-filled, the 1, 2 or 4 bytes starting at its offset (size code 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). The window holds the command at byte 0, the status at byte 2, the base address little-endian at bytes 4 to 7, and zero at bytes 1 and 3 and beyond byte 7.
- R8: `host_irq` follows `dev_irq` in both directions. A rising edge of `dev_irq` sets the interrupt flag (status bit 2), and a falling edge leaves it unchanged.
- R9: Writing 1 to status bit 1 or bit 2 clears that bit. Status bit 0 ignores writes. A set event in the same cycle as a clear wins.
- R10: An `eng_done` pulse with `eng_more` low clears the active flag. With `eng_more` high the flag stays set.
- R11: An `eng_err` pulse sets the error flag (status bit 1).
- R12: A `ptr_step` pulse advances `desc_ptr` by one descriptor size (8 bytes by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_off | input | 3 | Byte offset in the register window |
| acc_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| acc_wdata | input | 32 | Write data, right-justified |
| acc_rdata | output | 32 | Read data, right-justified, zero when no read |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_dir | output | 1 | Stored direction bit |
| eng_busy | input | 1 | Engine has a transfer in flight |
| eng_done | input | 1 | Engine finished its current work |
| eng_more | input | 1 | Qualifies `eng_done`: more work pending |
| eng_err | input | 1 | Engine error pulse |
| ptr_step | input | 1 | Engine consumed one descriptor |
| desc_ptr | output | 32 | Current descriptor pointer |
| dev_irq | input | 1 | Device interrupt line |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
Two sources can act on the same status bit in the same cycle. A host write-1-to-clear can land in the cycle where `dev_irq` rises, and another can land in the cycle where `eng_err` pulses. The bench drives all three in one cycle and expects both flags still set afterwards, because set must win. It also exercises the overlap of a stop request that is still waiting on `eng_busy` with a new run-bit rise. Both the directed reads and a per-cycle behavioural model judge each case.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

   localparam int WIN_BYTES = 8;
   localparam int LANE_CMD  = 0;
   localparam int LANE_STAT = 2;
   localparam int LANE_BASE = 4;

   localparam int CMD_RUN_BIT = 0;
   localparam int CMD_DIR_BIT = 3;

   localparam int ST_ACT_BIT = 0;
   localparam int ST_ERR_BIT = 1;
   localparam int ST_IRQ_BIT = 2;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   // Byte lanes of the 8-byte window touched by an access; lanes past 7 drop.
   function automatic logic [WIN_BYTES-1:0] lane_mask(input logic [2:0] off,
                                                      input logic [1:0] sz);
      logic [WIN_BYTES-1:0] m;
      unique case (sz)
         2'd0:    m = 8'h01;
         2'd1:    m = 8'h03;
         default: m = 8'h0F;
      endcase
      return m << off;
   endfunction

   function automatic logic [31:0] read_mask(input logic [1:0] sz);
      unique case (sz)
         2'd0:    return 32'h0000_00FF;
         2'd1:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/dmach_base_reg.sv
module dmach_base_reg #(
   parameter int ADDR_W     = 32,
   parameter int ALIGN_BITS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W/8-1:0]   lane_we,
   input  logic [ADDR_W-1:0]     lane_wd,
   output logic [ADDR_W-1:0]     base_q
);

   localparam int NLANES = ADDR_W / 8;
   localparam logic [ADDR_W-1:0] KEEP_MASK = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

   logic [ADDR_W-1:0] base_nx;

   always_comb begin
      base_nx = base_q;
      for (int i = 0; i < NLANES; i++) begin
         if (lane_we[i]) base_nx[i*8 +: 8] = lane_wd[i*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q <= '0;
      else        base_q <= base_nx & KEEP_MASK;
   end

   // Untouched lanes never move
   assert_lane_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_we == '0) |=> $stable(base_q));

endmodule

// File: rtl/dmach_run_ctrl.sv
module dmach_run_ctrl #(
   parameter int ADDR_W     = 32,
   parameter int DESC_BYTES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic              cmd_run_wd,
   input  logic              cmd_dir_wd,
   input  logic              err_clr,
   input  logic [ADDR_W-1:0] base_q,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic              eng_more,
   input  logic              eng_err,
   input  logic              ptr_step,
   output logic              run_q,
   output logic              dir_q,
   output logic              active_q,
   output logic              err_q,
   output logic              eng_start,
   output logic [ADDR_W-1:0] desc_ptr
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

   logic run_rise, run_fall, start_set, drain_now, fin_clear;
   logic stop_pend_q;

   assign run_rise  = cmd_we &  cmd_run_wd & ~run_q;
   assign run_fall  = cmd_we & ~cmd_run_wd &  run_q;
   assign start_set = run_rise & ~active_q;
   assign drain_now = run_fall ? ~eng_busy : (stop_pend_q & ~eng_busy & ~run_rise);
   assign fin_clear = eng_done & ~eng_more;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q       <= 1'b0;
         dir_q       <= 1'b0;
         active_q    <= 1'b0;
         stop_pend_q <= 1'b0;
         eng_start   <= 1'b0;
         err_q       <= 1'b0;
         desc_ptr    <= '0;
      end else begin
         if (cmd_we) begin
            run_q <= cmd_run_wd;
            dir_q <= cmd_dir_wd;
         end
         if (start_set)                   active_q <= 1'b1;
         else if (drain_now || fin_clear) active_q <= 1'b0;

         if (run_rise)                      stop_pend_q <= 1'b0;
         else if (run_fall && eng_busy)     stop_pend_q <= 1'b1;
         else if (stop_pend_q && !eng_busy) stop_pend_q <= 1'b0;

         eng_start <= start_set;

         if (run_rise)      desc_ptr <= base_q;
         else if (ptr_step) desc_ptr <= desc_ptr + STEP;

         if (eng_err)      err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
      end
   end

   assert_start_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   assert_start_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> active_q);
   assert_drain_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_pend_q && eng_busy && !eng_done) |=> active_q);
   assert_finish_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && !eng_more && !start_set) |=> !active_q);
   assert_err_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      eng_err |=> err_q);

endmodule

// File: rtl/dmach_irq_cap.sv
module dmach_irq_cap #(
   parameter bit IRQ_PASS_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dev_irq,
   input  logic irq_clr,
   output logic irq_stat,
   output logic host_irq
);

   logic irq_prev;
   logic irq_rise;

   assign irq_rise = dev_irq & ~irq_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_prev <= 1'b0;
         irq_stat <= 1'b0;
      end else begin
         irq_prev <= dev_irq;
         if (irq_rise)     irq_stat <= 1'b1;
         else if (irq_clr) irq_stat <= 1'b0;
      end
   end

   generate
      if (IRQ_PASS_REG) begin : g_pass_reg
         logic host_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) host_q <= 1'b0;
            else        host_q <= dev_irq;
         end
         assign host_irq = host_q;
      end else begin : g_pass_wire
         assign host_irq = dev_irq;
      end
   endgenerate

   assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_irq) |=> irq_stat);
   assert_irq_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_stat && !irq_clr) |=> irq_stat);

endmodule

// File: rtl/dmach_regfile.sv
module dmach_regfile #(
   parameter int ADDR_W       = 32,
   parameter int ALIGN_BITS   = 2,
   parameter int DESC_BYTES   = 8,
   parameter bit IRQ_PASS_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [2:0]        acc_off,
   input  logic [1:0]        acc_size,
   input  logic [31:0]       acc_wdata,
   output logic [31:0]       acc_rdata,
   output logic              eng_start,
   output logic              eng_dir,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic              eng_more,
   input  logic              eng_err,
   input  logic              ptr_step,
   output logic [ADDR_W-1:0] desc_ptr,
   input  logic              dev_irq,
   output logic              host_irq
);
   import dmach_pkg::*;

   localparam int NLANES = ADDR_W / 8;
   localparam int WIN_W  = WIN_BYTES * 8;

   generate
      if (ADDR_W % 8 != 0 || ADDR_W < 16 || ADDR_W > 32) begin : g_bad_addr
         $error("dmach_regfile: ADDR_W must be 16, 24 or 32");
      end
      if (ALIGN_BITS < 0 || ALIGN_BITS > 7) begin : g_bad_align
         $error("dmach_regfile: ALIGN_BITS out of range");
      end
      if (DESC_BYTES < 1 || (DESC_BYTES & (DESC_BYTES - 1)) != 0) begin : g_bad_desc
         $error("dmach_regfile: DESC_BYTES must be a power of two");
      end
   endgenerate

   logic [WIN_BYTES-1:0] wr_lanes;
   logic [WIN_W-1:0]     wr_win;
   logic [WIN_W-1:0]     rd_win;
   logic [WIN_W-1:0]     rd_shift;
   logic [ADDR_W-1:0]    base_q;
   logic                 run_q, dir_q, active_q, err_q, irq_stat;
   logic                 stat_we;
   logic [7:0]           cmd_byte, stat_byte;
   logic [31:0]          base_pad;

   assign wr_lanes = lane_mask(acc_off, acc_size) & {WIN_BYTES{acc_valid & acc_write}};
   assign wr_win   = {32'b0, acc_wdata} << {acc_off, 3'b000};
   assign stat_we  = wr_lanes[LANE_STAT];

   logic unused_lanes;
   assign unused_lanes = ^{wr_lanes[1], wr_lanes[3], wr_win[15:8], wr_win[31:24],
                           wr_win[7:4], wr_win[2:1], wr_win[23:19], wr_win[16],
                           rd_shift[63:32]};

   dmach_base_reg #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .lane_we (wr_lanes[LANE_BASE +: NLANES]),
      .lane_wd (wr_win[LANE_BASE*8 +: ADDR_W]),
      .base_q  (base_q)
   );

   dmach_run_ctrl #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_run (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_we     (wr_lanes[LANE_CMD]),
      .cmd_run_wd (wr_win[LANE_CMD*8 + CMD_RUN_BIT]),
      .cmd_dir_wd (wr_win[LANE_CMD*8 + CMD_DIR_BIT]),
      .err_clr    (stat_we & wr_win[LANE_STAT*8 + ST_ERR_BIT]),
      .base_q     (base_q),
      .eng_busy   (eng_busy),
      .eng_done   (eng_done),
      .eng_more   (eng_more),
      .eng_err    (eng_err),
      .ptr_step   (ptr_step),
      .run_q      (run_q),
      .dir_q      (dir_q),
      .active_q   (active_q),
      .err_q      (err_q),
      .eng_start  (eng_start),
      .desc_ptr   (desc_ptr)
   );

   dmach_irq_cap #(.IRQ_PASS_REG(IRQ_PASS_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .dev_irq  (dev_irq),
      .irq_clr  (stat_we & wr_win[LANE_STAT*8 + ST_IRQ_BIT]),
      .irq_stat (irq_stat),
      .host_irq (host_irq)
   );

   assign eng_dir = dir_q;

   always_comb begin
      cmd_byte                 = '0;
      cmd_byte[CMD_RUN_BIT]    = run_q;
      cmd_byte[CMD_DIR_BIT]    = dir_q;
      stat_byte                = '0;
      stat_byte[ST_ACT_BIT]    = active_q;
      stat_byte[ST_ERR_BIT]    = err_q;
      stat_byte[ST_IRQ_BIT]    = irq_stat;
   end

   assign base_pad  = 32'(base_q);
   assign rd_win    = {base_pad, 8'h00, stat_byte, 8'h00, cmd_byte};
   assign rd_shift  = rd_win >> {acc_off, 3'b000};
   assign acc_rdata = (acc_valid && !acc_write) ? (rd_shift[31:0] & read_mask(acc_size)) : 32'h0;

   // A rising run bit leaves the pointer equal to the base that was held
   assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lanes[LANE_CMD] && wr_win[CMD_RUN_BIT] && !run_q && wr_lanes[LANE_BASE +: NLANES] == '0)
      |=> desc_ptr == base_q);

endmodule

// File: tb/dmach_regfile_test.sv
`timescale 1ns/1ps
module dmach_regfile_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [2:0]  acc_off = '0;
   logic [1:0]  acc_size = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        eng_start, eng_dir;
   logic        eng_busy = 1'b0, eng_done = 1'b0, eng_more = 1'b0, eng_err = 1'b0, ptr_step = 1'b0;
   logic [31:0] desc_ptr;
   logic        dev_irq = 1'b0;
   logic        host_irq;

   int tests = 0;
   int fails = 0;
   bit done = 0;
   bit live = 0;

   always #4 clk = ~clk;

   dmach_regfile uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_off(acc_off), .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .eng_start(eng_start), .eng_dir(eng_dir), .eng_busy(eng_busy), .eng_done(eng_done),
      .eng_more(eng_more), .eng_err(eng_err), .ptr_step(ptr_step), .desc_ptr(desc_ptr),
      .dev_irq(dev_irq), .host_irq(host_irq)
   );

   // Behavioural reference model
   logic        m_run = 0, m_dir = 0, m_act = 0, m_err = 0, m_irq = 0, m_pend = 0, m_start = 0, m_prev = 0;
   logic [31:0] m_base = 0, m_ptr = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_dir = 0; m_act = 0; m_err = 0; m_irq = 0;
         m_pend = 0; m_start = 0; m_prev = 0; m_base = 0; m_ptr = 0;
      end else begin
         int nbytes;
         bit cw, sw, rise, fall, keep_pend;
         logic [7:0] cwd, swd;
         logic [31:0] nb;
         cw = 0; sw = 0; cwd = 0; swd = 0; nb = m_base;
         nbytes = (acc_size == 2'd0) ? 1 : (acc_size == 2'd1) ? 2 : 4;
         if (acc_valid && acc_write) begin
            for (int k = 0; k < nbytes; k++) begin
               int ln;
               ln = int'(acc_off) + k;
               if (ln == 0)                begin cw = 1; cwd = acc_wdata[8*k +: 8]; end
               else if (ln == 2)           begin sw = 1; swd = acc_wdata[8*k +: 8]; end
               else if (ln >= 4 && ln < 8) nb[8*(ln-4) +: 8] = acc_wdata[8*k +: 8];
            end
         end
         nb[1:0] = 2'b00;
         rise = cw && cwd[0] && !m_run;
         fall = cw && !cwd[0] && m_run;
         m_start = rise && !m_act;
         if (rise) m_ptr = m_base;
         else if (ptr_step) m_ptr = m_ptr + 32'd8;
         keep_pend = m_pend;
         if (rise && !m_act) m_act = 1;
         else if ((fall && !eng_busy) || (keep_pend && !eng_busy && !rise) || (eng_done && !eng_more)) m_act = 0;
         if (rise) m_pend = 0;
         else if (fall && eng_busy) m_pend = 1;
         else if (keep_pend && !eng_busy) m_pend = 0;
         if (eng_err) m_err = 1; else if (sw && swd[1]) m_err = 0;
         if (dev_irq && !m_prev) m_irq = 1; else if (sw && swd[2]) m_irq = 0;
         m_prev = dev_irq;
         if (cw) begin m_run = cwd[0]; m_dir = cwd[3]; end
         m_base = nb;
         live = 1;
      end
   end

   function automatic logic [31:0] model_read();
      logic [63:0] w;
      logic [31:0] r;
      w = {m_base, 8'h00, 5'b0, m_irq, m_err, m_act, 8'h00, 4'b0, m_dir, 2'b0, m_run};
      w = w >> (8 * int'(acc_off));
      r = w[31:0];
      if (acc_size == 2'd0) r = r & 32'hFF;
      else if (acc_size == 2'd1) r = r & 32'hFFFF;
      if (!(acc_valid && !acc_write)) r = 0;
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && live && !done) begin
         chk("R3 model eng_start", 32'(eng_start), 32'(m_start));
         chk("R12 model desc_ptr", desc_ptr, m_ptr);
         chk("R2 model eng_dir", 32'(eng_dir), 32'(m_dir));
         chk("R8 model host_irq", 32'(host_irq), 32'(dev_irq));
         chk("R7 model rdata", acc_rdata, model_read());
      end
   end

   // All tasks start and end 1 ns after a rising edge
   task automatic step(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [2:0] off, input logic [1:0] sz, input logic [31:0] d);
      acc_valid = 1; acc_write = 1; acc_off = off; acc_size = sz; acc_wdata = d;
      step();
      acc_valid = 0; acc_write = 0;
   endtask

   task automatic rd(input logic [2:0] off, input logic [1:0] sz, output logic [31:0] d);
      acc_valid = 1; acc_write = 0; acc_off = off; acc_size = sz;
      #3 d = acc_rdata;
      step();
      acc_valid = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      step(3);
      rst_n = 1;
      step();
      // R1 reset state
      rd(3'd0, 2'd2, v); chk("R1 cmd/status after reset", v, 32'h0);
      rd(3'd4, 2'd2, v); chk("R1 base after reset", v, 32'h0);
      chk("R1 desc_ptr after reset", desc_ptr, 32'h0);
      chk("R1 eng_start after reset", 32'(eng_start), 32'h0);
      // R6 lane writes and alignment
      wr(3'd4, 2'd2, 32'h1234_5677);
      rd(3'd4, 2'd2, v); chk("R6 word write, low bits zero", v, 32'h1234_5674);
      wr(3'd5, 2'd0, 32'h0000_00AB);
      wr(3'd6, 2'd1, 32'h0000_CDEF);
      rd(3'd4, 2'd2, v); chk("R6 byte and half lanes", v, 32'hCDEF_AB74);
      // R7 read lanes
      rd(3'd5, 2'd1, v); chk("R7 half read at 5", v, 32'h0000_EFAB);
      rd(3'd7, 2'd2, v); chk("R7 read past window", v, 32'h0000_00CD);
      // R2 command mask, run stays 0
      wr(3'd0, 2'd0, 32'hFE);
      rd(3'd0, 2'd0, v); chk("R2 cmd masked", v, 32'h08);
      chk("R2 eng_dir", 32'(eng_dir), 32'h1);
      chk("R4 no start with run unchanged", 32'(eng_start), 32'h0);
      // R3 start
      wr(3'd0, 2'd0, 32'hFF);
      chk("R3 start pulse", 32'(eng_start), 32'h1);
      chk("R3 pointer reload", desc_ptr, 32'hCDEF_AB74);
      step();
      chk("R3 pulse one cycle", 32'(eng_start), 32'h0);
      rd(3'd0, 2'd2, v); chk("R7 cmd+status word", v, 32'h0001_0009);
      // R12 pointer step
      ptr_step = 1; step(); ptr_step = 0;
      chk("R12 pointer advance", desc_ptr, 32'hCDEF_AB7C);
      // R4 run unchanged
      wr(3'd0, 2'd0, 32'h01);
      chk("R4 no pulse", 32'(eng_start), 32'h0);
      chk("R4 pointer kept", desc_ptr, 32'hCDEF_AB7C);
      chk("R2 dir cleared", 32'(eng_dir), 32'h0);
      // R5 drain
      eng_busy = 1;
      wr(3'd0, 2'd0, 32'h00);
      step(3);
      rd(3'd2, 2'd0, v); chk("R5 active held while busy", v, 32'h01);
      eng_busy = 0; step();
      rd(3'd2, 2'd0, v); chk("R5 active cleared after drain", v, 32'h00);
      // R3 restart reloads base
      wr(3'd0, 2'd0, 32'h01);
      chk("R3 restart pulse", 32'(eng_start), 32'h1);
      chk("R3 reload on restart", desc_ptr, 32'hCDEF_AB74);
      // R10 finish
      eng_done = 1; eng_more = 1; step(); eng_done = 0; eng_more = 0;
      rd(3'd2, 2'd0, v); chk("R10 more pending keeps active", v, 32'h01);
      eng_done = 1; step(); eng_done = 0;
      rd(3'd2, 2'd0, v); chk("R10 done clears active", v, 32'h00);
      // R3/R5 rise while a stop is pending
      wr(3'd0, 2'd0, 32'h00);
      wr(3'd0, 2'd0, 32'h01);
      eng_busy = 1;
      wr(3'd0, 2'd0, 32'h00);
      wr(3'd0, 2'd0, 32'h01);
      chk("R3 no pulse while active", 32'(eng_start), 32'h0);
      eng_busy = 0; step(2);
      rd(3'd2, 2'd0, v); chk("R5 restart cancels pending stop", v, 32'h01);
      // R8 interrupt
      dev_irq = 1;
      #3 chk("R8 host_irq high", 32'(host_irq), 32'h1);
      step();
      rd(3'd2, 2'd0, v); chk("R8 irq flag set", v, 32'h05);
      dev_irq = 0;
      #3 chk("R8 host_irq low", 32'(host_irq), 32'h0);
      step();
      rd(3'd2, 2'd0, v); chk("R8 flag kept on fall", v, 32'h05);
      // R9 write-1-to-clear
      wr(3'd2, 2'd0, 32'h01);
      rd(3'd2, 2'd0, v); chk("R9 bit0 ignores write", v, 32'h05);
      wr(3'd2, 2'd0, 32'h04);
      rd(3'd2, 2'd0, v); chk("R9 irq cleared", v, 32'h01);
      // R11 error
      eng_err = 1; step(); eng_err = 0;
      rd(3'd2, 2'd0, v); chk("R11 error set", v, 32'h03);
      // R9 collision: set and clear in one cycle
      dev_irq = 1; eng_err = 1;
      wr(3'd2, 2'd0, 32'h06);
      eng_err = 0;
      rd(3'd2, 2'd0, v); chk("R9 set wins over clear", v, 32'h07);
      wr(3'd2, 2'd0, 32'h06);
      rd(3'd2, 2'd0, v); chk("R9 clear with line still high", v, 32'h01);
      dev_irq = 0; step();
      // R1 reset mid-run
      rst_n = 0; step(); rst_n = 1; step();
      rd(3'd0, 2'd2, v); chk("R1 cmd/status after second reset", v, 32'h0);
      rd(3'd4, 2'd2, v); chk("R1 base after second reset", v, 32'h0);
      chk("R1 pointer after second reset", desc_ptr, 32'h0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule